// File: doc/BRIEF.md
# Serial LED Matrix Row Loader

This block refreshes one row of a 10-row by 14-column LED matrix board per update. The board holds an 18-bit external shift register with no clock enable, a row decoder and line drivers. The block drives it through three wires: a serial data line, a shift clock and a display-enable. When the controller pulses `start_i` while `ready_o` is high, the block captures the current row number and a 14-bit column word into a parallel-load shift register. It then shifts the 18 bits out, row address first and column bits after.

Each serial bit occupies two system clock cycles. The data line is driven by a flop on the rising system clock edge. The shift clock comes from a separate flop on the falling edge, so the two outputs never move on the same edge. Once the last bit is out, the shift clock stays low and display-enable is held high for `HOLD_CYCLES` system clock cycles. At the end of that period the internal row counter advances, wrapping after the last row. A one-cycle `done_o` then tells the controller that the next update may be started.

A test mode replaces the column word with seven switch inputs, each of which lights a pair of adjacent columns. The hold count is a parameter. For 50 µs of display per row at 50 MHz, it is 2500.

Top module: `led_row_loader`

## Requirements
- R1: Each update produces exactly 18 rising edges on `sclk_o`. The bits seen on `sdata_o` at those edges are the 4-bit row number (most significant bit first), then `cols_i[13]` (the leftmost column) down to `cols_i[0]`.
- R2: `sdata_o` changes only on rising `clk_i` edges and `sclk_o` only on falling ones. `sdata_o` never changes while `sclk_o` is high.
- R3: After the last shift clock pulse, `disp_en_o` is high for exactly `HOLD_CYCLES` clock cycles. No rising edge of `sclk_o` occurs while `disp_en_o` is high. An update keeps `ready_o` low for 36 + `HOLD_CYCLES` cycles.
- R4: The row number sent is 0 on the first update after reset and advances by one after each display period. It wraps from 9 to 0, so it never leaves 0..9.
- R5: With `sw_mode_i` = 1, column bit c (c = 0..13) carries `sw_i[c/2]` and `cols_i` is ignored.
- R6: `ready_o` is high only while the block is idle. A `start_i` pulse while `ready_o` is low starts no further update and produces no extra shift clock pulse.
- R7: `done_o` is high for exactly one cycle: the first idle cycle after display-enable falls.
- R8: While `rst_ni` is low, including in the middle of an update, `ready_o` is 1 and `sclk_o`, `disp_en_o` and `done_o` are 0. The next update after reset sends row 0.
- R9: Column data and mode are captured at the accepted start. Changes to `cols_i`, `sw_i` or `sw_mode_i` during an update do not alter the bits sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an update; honoured only when ready |
| cols_i | input | 14 | Column word, bit 13 = leftmost column |
| sw_mode_i | input | 1 | 1 selects the switch-pair column source |
| sw_i | input | 7 | Test switches, each drives two adjacent columns |
| ready_o | output | 1 | Idle, able to accept a start |
| done_o | output | 1 | One-cycle pulse when an update finishes |
| sdata_o | output | 1 | Serial data to the board |
| sclk_o | output | 1 | Shift clock to the board, idle low |
| disp_en_o | output | 1 | Board display-enable |

## Verification
The assertions assume that `start_i` and the column inputs change only between rising clock edges. They also assume that `HOLD_CYCLES` is at least one, so that a display period exists between any two shift sequences. The bench drives every input on the falling clock edge, keeps the reset release away from the rising edge, and uses a small hold count. It sweeps all 128 switch patterns and runs enough normal updates to cross the row wrap. It also pokes `start_i` and the column inputs while the block is busy.

// File: rtl/led_loader_pkg.sv
package led_loader_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_DISP  = 2'd2
  } ldr_state_e;
endpackage

// File: rtl/led_frame_sreg.sv
module led_frame_sreg #(
  parameter int ROW_W = 4,
  parameter int COL_W = 14,
  localparam int FRAME_W = ROW_W + COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] cols_i,
  output logic             ser_o
);
  logic [FRAME_W-1:0] sreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sreg_q <= '0;
    else if (load_i)   sreg_q <= {row_i, cols_i};
    else if (shift_i)  sreg_q <= {sreg_q[FRAME_W-2:0], 1'b0};
  end

  assign ser_o = sreg_q[FRAME_W-1];
endmodule

// File: rtl/led_sclk_gen.sv
// Shift clock from a falling-edge flop: never shares an edge with data.
module led_sclk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic sclk_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_o <= 1'b0;
    else         sclk_o <= pulse_i;
  end
endmodule

// File: rtl/led_hold_timer.sv
module led_hold_timer #(
  parameter int HOLD_CYCLES = 2500,
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [CNT_W-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == CNT_W'(HOLD_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/led_row_ctr.sv
module led_row_ctr #(
  parameter int ROWS  = 10,
  parameter int ROW_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (adv_i)  row_o <= (row_o == ROW_W'(ROWS - 1)) ? '0 : row_o + 1'b1;
  end
endmodule

// File: rtl/led_row_loader.sv
module led_row_loader
  import led_loader_pkg::*;
#(
  parameter int ROWS        = 10,
  parameter int ROW_W       = 4,
  parameter int NUM_SW      = 7,
  parameter int HOLD_CYCLES = 2500,
  localparam int COL_W   = 2 * NUM_SW,
  localparam int FRAME_W = ROW_W + COL_W,
  localparam int BIT_W   = $clog2(FRAME_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  cols_i,
  input  logic              sw_mode_i,
  input  logic [NUM_SW-1:0] sw_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              sdata_o,
  output logic              sclk_o,
  output logic              disp_en_o
);
  ldr_state_e       state_q;
  logic             ph_q;
  logic [BIT_W-1:0] bit_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] sw_cols, col_sel;
  logic             accept, last_bit, shift_en, hold_done;

  // each switch lights two adjacent columns
  for (genvar c = 0; c < COL_W; c++) begin : g_sw_pair
    assign sw_cols[c] = sw_i[c/2];
  end

  assign col_sel  = sw_mode_i ? sw_cols : cols_i;
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign last_bit = (state_q == ST_SHIFT) && ph_q && (bit_q == BIT_W'(FRAME_W - 1));
  assign shift_en = (state_q == ST_SHIFT) && ph_q && !last_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ph_q    <= 1'b0;
      bit_q   <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= hold_done;
      ph_q   <= (state_q == ST_SHIFT) ? ~ph_q : 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          state_q <= ST_SHIFT;
          bit_q   <= '0;
        end
        ST_SHIFT: begin
          if (ph_q) bit_q <= bit_q + 1'b1;
          if (last_bit) state_q <= ST_DISP;
        end
        ST_DISP: if (hold_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o   = (state_q == ST_IDLE);
  assign disp_en_o = (state_q == ST_DISP);

  led_frame_sreg #(.ROW_W(ROW_W), .COL_W(COL_W)) i_sreg (
    .clk_i, .rst_ni,
    .load_i (accept),
    .shift_i(shift_en),
    .row_i  (row_q),
    .cols_i (col_sel),
    .ser_o  (sdata_o)
  );

  led_sclk_gen i_sclk (
    .clk_i, .rst_ni,
    .pulse_i((state_q == ST_SHIFT) && !ph_q),
    .sclk_o
  );

  led_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) i_hold (
    .clk_i, .rst_ni,
    .run_i   (state_q == ST_DISP),
    .expire_o(hold_done)
  );

  led_row_ctr #(.ROWS(ROWS), .ROW_W(ROW_W)) i_row (
    .clk_i, .rst_ni,
    .adv_i(hold_done),
    .row_o(row_q)
  );
endmodule

// File: rtl/led_row_loader_chk.sv
module led_row_loader_chk #(
  parameter int ROWS  = 10,
  parameter int ROW_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic             done_o,
  input logic             sdata_o,
  input logic             sclk_o,
  input logic             disp_en_o,
  input logic [ROW_W-1:0] row_i
);
  a_r2_data_held_while_sclk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |=> $stable(sdata_o));

  a_r3_no_sclk_in_disp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disp_en_o |-> !sclk_o);

  a_r7_disp_end_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(disp_en_o) |-> done_o);

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_ready_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!disp_en_o && !sclk_o));

  a_r4_row_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_i < ROW_W'(ROWS));

  a_r4_row_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (row_i == (($past(row_i) == ROW_W'(ROWS - 1)) ? '0 : $past(row_i) + 1'b1)));
endmodule

bind led_row_loader led_row_loader_chk #(.ROWS(ROWS), .ROW_W(ROW_W)) i_chk (
  .clk_i, .rst_ni, .ready_o, .done_o, .sdata_o, .sclk_o, .disp_en_o,
  .row_i(row_q)
);

// File: tb/test_led_row_loader.sv
module test_led_row_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;
  localparam int ROWS = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [13:0] cols_i = '0;
  logic        sw_mode_i = 1'b0;
  logic [6:0]  sw_i = '0;
  logic        ready_o, done_o, sdata_o, sclk_o, disp_en_o;

  int n_chk = 0, n_bad = 0;
  int exp_row = 0;
  int npulse = 0, clk_in_disp = 0, collide = 0;
  logic [17:0] brd = '0;
  time t_data = 0, t_clk = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  led_row_loader #(.HOLD_CYCLES(HOLD)) i_led_row_loader (
    .clk_i, .rst_ni, .start_i, .cols_i, .sw_mode_i, .sw_i,
    .ready_o, .done_o, .sdata_o, .sclk_o, .disp_en_o
  );

  // board model: shifts on rising sclk
  always @(posedge sclk_o) begin
    brd = {brd[16:0], sdata_o};
    npulse++;
    if (disp_en_o) clk_in_disp++;
  end
  always @(sdata_o) begin
    t_data = $time;
    if (rst_ni && (t_clk == $time || sclk_o)) collide++;
  end
  always @(sclk_o) begin
    t_clk = $time;
    if (rst_ni && t_data == $time) collide++;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic update(input logic [13:0] c, input logic m, input logic [6:0] s, input bit poke);
    logic [13:0] exp_cols;
    int dcnt = 0, bcnt = 0, guard = 0;
    for (int k = 0; k < 14; k++) exp_cols[k] = m ? s[k/2] : c[k];
    npulse = 0; clk_in_disp = 0;
    @(negedge clk_i);
    cols_i = c; sw_mode_i = m; sw_i = s; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && guard < 5000) begin
      if (!ready_o) bcnt++;
      if (disp_en_o) dcnt++;
      start_i = poke && guard == 10;
      if (poke && guard == 10) begin cols_i = ~c; sw_i = ~s; sw_mode_i = ~m; end
      @(negedge clk_i);
      guard++;
    end
    start_i = 1'b0;
    chk("R1 frame bits", brd, {4'(exp_row), exp_cols});
    chk("R1 sclk pulse count", npulse, 18);
    chk("R3 display cycles", dcnt, HOLD);
    chk("R3 busy cycles", bcnt, 36 + HOLD);
    chk("R3 sclk during display", clk_in_disp, 0);
    chk("R7 done with ready", {done_o, ready_o}, 2'b11);
    @(negedge clk_i);
    chk("R7 done single cycle", done_o, 0);
    if (poke) begin
      repeat (5) @(negedge clk_i);
      chk("R6 busy start ignored ready", ready_o, 1);
      chk("R6 busy start no extra pulse", npulse, 18);
    end
    exp_row = (exp_row + 1) % ROWS;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R8 reset ready", ready_o, 1);
    chk("R8 reset sclk", sclk_o, 0);
    chk("R8 reset disp_en", disp_en_o, 0);
    chk("R8 reset done", done_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // normal mode, R4 crosses the wrap 9 -> 0
    for (int u = 0; u < 13; u++) begin
      logic [13:0] c;
      c = (u == 0) ? 14'h0000 : (u == 1) ? 14'h3FFF : (u == 2) ? 14'h2AAA :
          (14'h0001 << (u - 3)) ^ 14'h0C03;
      update(c, 1'b0, 7'h00, 1'b0);
    end

    // R5: all switch patterns, cols_i set against them to show it is ignored
    for (int s = 0; s < 128; s++) update(~{7'(s), 7'(s)}, 1'b1, 7'(s), 1'b0);

    // R6/R9: start and input changes while busy
    update(14'h1234, 1'b0, 7'h55, 1'b1);
    update(14'h0F0F, 1'b1, 7'h2B, 1'b1);

    // R8: reset during display
    @(negedge clk_i);
    cols_i = 14'h3C3C; sw_mode_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!disp_en_o) @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R8 mid reset disp_en", disp_en_o, 0);
    chk("R8 mid reset sclk", sclk_o, 0);
    chk("R8 mid reset ready", ready_o, 1);
    rst_ni = 1'b1;
    exp_row = 0;
    @(negedge clk_i);
    update(14'h2001, 1'b0, 7'h00, 1'b0);  // R8 row restarts at 0

    chk("R2 data/clock edge separation", collide, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule